// File: doc/BRIEF.md
# Codirectional Octet Receiver with Slip Buffer

This block takes the two active-low rails of a 64 kbit/s codirectional line, as delivered by a line receiver, and turns them into 8-bit bursts on a 2.048 Mbit/s PCM time-slot. A recovered clock enable (`rec_ce`) marks the two sample points of every bit. `rec_half` tells the block whether the strobe is the first or the second half of the bit. In the first half the block records the polarity of the block's leading pulse. In the second half it decides the bit value. A block whose polarity equals that of the block before it is a polarity violation. Such a violation marks the final bit of an octet.

The octet framer collects bits least-significant first. When a violation is missing, it keeps counting from the last one it saw, so framing is held. It counts consecutive missed violations and raises a loss alarm. When the supervision input is low, it marks an octet closed without a violation for blanking. Completed octets go into one of two holding registers. The readout side shifts an octet out on the selected time-slot on each `pcm_ce` strobe. A slow reader skips octets, because the writer overwrites the unread register. A fast reader gets the last octet again.

Top module: `codir_octet_rx`

## Requirements
- R1: Both rails are active-low (0 = pulse present). The first-half sample takes the block polarity: positive if `rx_pos_n` is low, else negative. In the second-half sample, a pulse on either rail decodes as bit 0, and both rails high decodes as bit 1.
- R2: A block with the same polarity as the previous block is a violation. A violation arriving as the eighth bit closes the octet. The first received bit becomes D0, which is the first bit shifted out.
- R3: If the eighth bit arrives without a violation while `lock_sup` is high, the octet still closes at that bit, its data is passed unchanged, and framing continues.
- R4: If the eighth bit arrives without a violation while `lock_sup` is low, that octet reads out as all ones.
- R5: `loss_alarm` goes high when eight consecutive octets close without a violation. It goes low when a violation arrives as an eighth bit.
- R6: A violation arriving before the eighth bit closes the octet early. Its unfilled positions read as ones, and the next bit starts a new octet.
- R7: While `blank_force` is high, `pcm_out` is forced high from the next clock on.
- R8: `ts_pick` high selects `ts1_in` and low selects `ts2_in`. On the first `pcm_ce` with the selected slot high, D0 appears on `pcm_out` after that edge. D1 to D7 follow on later strobes. Outside the slot, and on strobes after the eighth, `pcm_out` is high.
- R9: If no new octet has completed since the previous readout, the same octet is read out again.
- R10: If two octets complete between readouts, the newer one is read out and the older one is dropped.
- R11: After reset, `pcm_out` is high and `loss_alarm` is low, and a readout before any octet has completed gives all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_pos_n | input | 1 | Positive-pulse rail, active low |
| rx_neg_n | input | 1 | Negative-pulse rail, active low |
| rec_ce | input | 1 | Recovered half-bit sample strobe |
| rec_half | input | 1 | 0 = first-half sample, 1 = second-half sample |
| lock_sup | input | 1 | Low: blank octets that closed without a violation |
| ts1_in | input | 1 | Time-slot envelope 1 |
| ts2_in | input | 1 | Time-slot envelope 2 |
| ts_pick | input | 1 | 1 selects envelope 1, 0 selects envelope 2 |
| pcm_ce | input | 1 | PCM bit strobe (2.048 MHz rising edge) |
| blank_force | input | 1 | Forces PCM output to ones |
| pcm_out | output | 1 | PCM serial output |
| loss_alarm | output | 1 | Missing-violation alarm |

## Verification
The hardest states to reach are the ones that depend on the line history rather than on the current octet. These are an alarm reached after exactly eight missed violations, and an early violation that cuts an octet short. The stimulus is a line generator that tracks the last block polarity, so it can emit a violation or a plain alternation on any bit. It walks the framer through seven misses, then the eighth, then one in-position violation, checking the alarm at each step. Slip cases come from ordering writes and reads sequentially: two octets before one read, and two reads after one octet.

// File: rtl/codir_pkg.sv
package codir_pkg;
    typedef struct packed {
        logic vld;
        logic val;
        logic viol;
    } codir_bit_t;
endpackage

// File: rtl/codir_bit_decoder.sv
module codir_bit_decoder
    import codir_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pos_n_i,
    input  logic       neg_n_i,
    input  logic       ce_i,
    input  logic       half_i,
    output codir_bit_t bit_o
);
    typedef struct packed {
        logic       cur_pol;
        logic       prev_pol;
        logic       have_prev;
        codir_bit_t bit_out;
    } dec_st_t;

    dec_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.bit_out = '0;
        if (ce_i && !half_i) begin
            st_d.cur_pol = ~pos_n_i;
        end else if (ce_i && half_i) begin
            st_d.bit_out.vld  = 1'b1;
            st_d.bit_out.val  = pos_n_i & neg_n_i;
            st_d.bit_out.viol = st_q.have_prev & (st_q.cur_pol == st_q.prev_pol);
            st_d.prev_pol     = st_q.cur_pol;
            st_d.have_prev    = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bit_o = st_q.bit_out;

    // R2
    viol_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_o.viol |-> bit_o.vld);
endmodule

// File: rtl/codir_octet_framer.sv
module codir_octet_framer
    import codir_pkg::*;
#(
    parameter int OCT_W      = 8,
    parameter int MISS_LIMIT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  codir_bit_t       bit_i,
    input  logic             lock_sup_i,
    output logic             oct_vld_o,
    output logic [OCT_W-1:0] oct_o,
    output logic             oct_blank_o,
    output logic             alarm_o
);
    localparam int CNT_W  = $clog2(OCT_W);
    localparam int MISS_W = $clog2(MISS_LIMIT + 1);
    localparam logic [CNT_W-1:0]  LAST_POS = CNT_W'(OCT_W - 1);
    localparam logic [MISS_W-1:0] MISS_MAX = MISS_W'(MISS_LIMIT);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [OCT_W-1:0]  sh;
        logic [MISS_W-1:0] miss;
        logic              alarm;
        logic              done;
        logic [OCT_W-1:0]  word;
        logic              blank;
    } frm_st_t;

    frm_st_t st_d, st_q;
    logic [OCT_W-1:0] w_fill;

    always_comb begin
        st_d   = st_q;
        st_d.done = 1'b0;
        w_fill = st_q.sh;
        w_fill[st_q.cnt] = bit_i.val;
        if (bit_i.vld) begin
            if (bit_i.viol) begin
                st_d.done  = 1'b1;
                st_d.word  = w_fill;
                st_d.blank = 1'b0;
                st_d.cnt   = '0;
                st_d.sh    = '1;
                if (st_q.cnt == LAST_POS) begin
                    st_d.miss  = '0;
                    st_d.alarm = 1'b0;
                end
            end else if (st_q.cnt == LAST_POS) begin
                st_d.done  = 1'b1;
                st_d.word  = w_fill;
                st_d.blank = ~lock_sup_i;
                st_d.cnt   = '0;
                st_d.sh    = '1;
                if (st_q.miss != MISS_MAX) st_d.miss = st_q.miss + 1'b1;
                if (st_d.miss == MISS_MAX) st_d.alarm = 1'b1;
            end else begin
                st_d.sh  = w_fill;
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.sh   <= '1;
            st_q.word <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign oct_vld_o   = st_q.done;
    assign oct_o       = st_q.word;
    assign oct_blank_o = st_q.blank;
    assign alarm_o     = st_q.alarm;

    // R5
    alarm_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_o) |-> $past(bit_i.vld && !bit_i.viol));
    // R5
    alarm_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(alarm_o) |-> $past(bit_i.vld && bit_i.viol));
endmodule

// File: rtl/codir_slip_reader.sv
module codir_slip_reader #(
    parameter int OCT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             oct_vld_i,
    input  logic [OCT_W-1:0] oct_i,
    input  logic             oct_blank_i,
    input  logic             ts1_i,
    input  logic             ts2_i,
    input  logic             ts_pick_i,
    input  logic             pcm_ce_i,
    input  logic             blank_force_i,
    output logic             pcm_o
);
    localparam int IDX_W = $clog2(OCT_W) + 1;
    localparam logic [IDX_W-1:0] IDX_END = IDX_W'(OCT_W);

    typedef struct packed {
        logic [1:0][OCT_W-1:0] bufs;
        logic [1:0]            blks;
        logic                  last;
        logic                  rd_sel;
        logic                  active;
        logic [IDX_W-1:0]      idx;
        logic                  pcm;
    } rd_st_t;

    rd_st_t st_d, st_q;
    logic   sel_ts;
    logic   tgt;

    always_comb begin
        st_d   = st_q;
        sel_ts = ts_pick_i ? ts1_i : ts2_i;
        tgt    = st_q.active ? ~st_q.rd_sel : ~st_q.last;
        if (oct_vld_i) begin
            st_d.bufs[tgt] = oct_i;
            st_d.blks[tgt] = oct_blank_i;
            st_d.last      = tgt;
        end
        if (pcm_ce_i) begin
            if (!sel_ts) begin
                st_d.active = 1'b0;
                st_d.pcm    = 1'b1;
            end else if (!st_q.active) begin
                st_d.active = 1'b1;
                st_d.rd_sel = st_q.last;
                st_d.idx    = IDX_W'(1);
                st_d.pcm    = st_q.bufs[st_q.last][0] | st_q.blks[st_q.last];
            end else if (st_q.idx != IDX_END) begin
                st_d.pcm = st_q.bufs[st_q.rd_sel][st_q.idx[IDX_W-2:0]] | st_q.blks[st_q.rd_sel];
                st_d.idx = st_q.idx + 1'b1;
            end else begin
                st_d.pcm = 1'b1;
            end
        end
        if (blank_force_i) st_d.pcm = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.bufs <= '1;
            st_q.pcm  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign pcm_o = st_q.pcm;

    // R8
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pcm_ce_i && !(ts_pick_i ? ts1_i : ts2_i)) |=> pcm_o);
    // R7
    blank_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blank_force_i |=> pcm_o);
    // R10
    rd_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && $past(st_q.active)) |-> $stable(st_q.rd_sel));
endmodule

// File: rtl/codir_octet_rx.sv
module codir_octet_rx
    import codir_pkg::*;
#(
    parameter int OCT_W      = 8,
    parameter int MISS_LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_pos_n,
    input  logic rx_neg_n,
    input  logic rec_ce,
    input  logic rec_half,
    input  logic lock_sup,
    input  logic ts1_in,
    input  logic ts2_in,
    input  logic ts_pick,
    input  logic pcm_ce,
    input  logic blank_force,
    output logic pcm_out,
    output logic loss_alarm
);
    codir_bit_t       dec_bit;
    logic             oct_vld;
    logic [OCT_W-1:0] oct_word;
    logic             oct_blank;

    codir_bit_decoder u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .pos_n_i (rx_pos_n),
        .neg_n_i (rx_neg_n),
        .ce_i    (rec_ce),
        .half_i  (rec_half),
        .bit_o   (dec_bit)
    );

    codir_octet_framer #(.OCT_W(OCT_W), .MISS_LIMIT(MISS_LIMIT)) u_frm (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_i       (dec_bit),
        .lock_sup_i  (lock_sup),
        .oct_vld_o   (oct_vld),
        .oct_o       (oct_word),
        .oct_blank_o (oct_blank),
        .alarm_o     (loss_alarm)
    );

    codir_slip_reader #(.OCT_W(OCT_W)) u_rd (
        .clk           (clk),
        .rst_n         (rst_n),
        .oct_vld_i     (oct_vld),
        .oct_i         (oct_word),
        .oct_blank_i   (oct_blank),
        .ts1_i         (ts1_in),
        .ts2_i         (ts2_in),
        .ts_pick_i     (ts_pick),
        .pcm_ce_i      (pcm_ce),
        .blank_force_i (blank_force),
        .pcm_o         (pcm_out)
    );
endmodule

// File: tb/codir_octet_rx_tb.sv
`timescale 1ns/1ps
module codir_octet_rx_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_pos_n = 1'b1, rx_neg_n = 1'b1, rec_ce = 1'b0, rec_half = 1'b0;
    logic lock_sup = 1'b1, ts1_in = 1'b0, ts2_in = 1'b0, ts_pick = 1'b1;
    logic pcm_ce = 1'b1, blank_force = 1'b0;
    logic pcm_out, loss_alarm;

    int n_chk = 0, n_fail = 0;
    logic line_pol = 1'b0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    codir_octet_rx dut_i (
        .clk(clk), .rst_n(rst_n), .rx_pos_n(rx_pos_n), .rx_neg_n(rx_neg_n),
        .rec_ce(rec_ce), .rec_half(rec_half), .lock_sup(lock_sup),
        .ts1_in(ts1_in), .ts2_in(ts2_in), .ts_pick(ts_pick), .pcm_ce(pcm_ce),
        .blank_force(blank_force), .pcm_out(pcm_out), .loss_alarm(loss_alarm)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic drive_half(input logic half, input logic pulse, input logic pol);
        @(negedge clk);
        rx_pos_n = ~(pulse & pol);
        rx_neg_n = ~(pulse & ~pol);
        rec_half = half;
        rec_ce   = 1'b1;
        @(negedge clk);
        rec_ce = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_bit(input logic b, input logic viol);
        logic p;
        p = viol ? line_pol : ~line_pol;
        line_pol = p;
        drive_half(1'b0, 1'b1, p);
        drive_half(1'b1, ~b, p);
    endtask

    task automatic send_octet(input logic [7:0] v, input logic with_viol);
        for (int i = 0; i < 8; i++) send_bit(v[i], with_viol && (i == 7));
        repeat (4) @(negedge clk);
    endtask

    task automatic read_slot(input logic pick, input logic use1, output logic [7:0] v);
        @(negedge clk);
        ts_pick = pick;
        ts1_in  = use1;
        ts2_in  = ~use1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            v[i] = pcm_out;
        end
        ts1_in = 1'b0;
        ts2_in = 1'b0;
        @(negedge clk);
        check("R8 idle after slot", {7'b0, pcm_out}, 8'h01);
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        check("R11 pcm_out at reset", {7'b0, pcm_out}, 8'h01);
        check("R11 alarm at reset", {7'b0, loss_alarm}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        read_slot(1'b1, 1'b1, r);
        check("R11 empty read", r, 8'hFF);

        // R1 R2 R8: every octet value, alternating slot selection
        for (int v = 0; v < 256; v++) begin
            send_octet(8'(v), 1'b1);
            read_slot(v[0], v[0], r);
            check("R1 R2 R8 octet sweep", r, 8'(v));
        end
        check("R5 no alarm with violations", {7'b0, loss_alarm}, 8'h00);

        // R8 unselected slot gives ones
        send_octet(8'h3A, 1'b1);
        read_slot(1'b1, 1'b0, r);
        check("R8 wrong slot", r, 8'hFF);
        read_slot(1'b0, 1'b0, r);
        check("R8 slot 2 select", r, 8'h3A);
        // R9 repeat
        read_slot(1'b1, 1'b1, r);
        check("R9 repeat", r, 8'h3A);
        // R10 delete
        send_octet(8'h11, 1'b1);
        send_octet(8'h22, 1'b1);
        read_slot(1'b1, 1'b1, r);
        check("R10 delete", r, 8'h22);

        // R3 flywheel, miss 1
        send_octet(8'h6B, 1'b0);
        read_slot(1'b1, 1'b1, r);
        check("R3 flywheel data", r, 8'h6B);
        // R4 blank on supervision, miss 2
        lock_sup = 1'b0;
        send_octet(8'h6B, 1'b0);
        read_slot(1'b1, 1'b1, r);
        check("R4 supervision blank", r, 8'hFF);
        lock_sup = 1'b1;
        // R5 misses 3..7
        for (int k = 0; k < 5; k++) send_octet(8'h0F, 1'b0);
        check("R5 seven misses", {7'b0, loss_alarm}, 8'h00);
        send_octet(8'h0F, 1'b0);
        check("R5 eight misses", {7'b0, loss_alarm}, 8'h01);
        send_octet(8'h99, 1'b1);
        check("R5 alarm cleared", {7'b0, loss_alarm}, 8'h00);
        read_slot(1'b1, 1'b1, r);
        check("R3 framing kept", r, 8'h99);

        // R6 early violation
        send_bit(1'b1, 1'b0);
        send_bit(1'b0, 1'b0);
        send_bit(1'b1, 1'b1);
        repeat (4) @(negedge clk);
        read_slot(1'b1, 1'b1, r);
        check("R6 partial octet", r, 8'hFD);
        send_octet(8'h3C, 1'b1);
        read_slot(1'b1, 1'b1, r);
        check("R6 realigned", r, 8'h3C);

        // R7 blank input
        send_octet(8'h42, 1'b1);
        blank_force = 1'b1;
        read_slot(1'b1, 1'b1, r);
        check("R7 blank forced", r, 8'hFF);
        blank_force = 1'b0;
        read_slot(1'b1, 1'b1, r);
        check("R7 blank released", r, 8'h42);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule